// File: doc/BRIEF.md
# Reloadable Down-Counter Timer

This block is a down-counting timer with a reload register and a control/status register, both reached through a simple single-cycle register bus. It runs in one of two clocking modes. In internal-clock mode, a start event copies the reload value into the counter, and the counter then steps down once per clock. The start event is either a software write or a chosen edge of an external input. In event-count mode, a software start arms the counter, and each chosen edge of the external input then removes one from the count.

The counter underflows when it steps from zero to all ones. On underflow it either reloads and keeps running, or it parks at all ones and stops. Every underflow sets a sticky flag. The flag can only be cleared by writing zero to it, and it drives an interrupt request through an enable bit. The timer output pin behaves in one of two ways, each with a selectable polarity. In one-shot use it is a level that marks the counting window. In reload use it is a square wave that flips on every underflow.

The block has no data stream, so every pin is a plain control or status signal. A write is taken on the clock edge where `bus_sel` and `bus_wr` are both high. Reads are combinational from `bus_addr`.

Top module: `reload_timer`

## Requirements
- R1: After reset, the control word (address 0), the reload register (address 1) and the counter (address 2) all read 0, and `tmr_out` and `irq` are low.
- R2: Writing the control word with bit 0 (start) and bit 1 (count enable) both set loads the reload value into the counter on that edge. In internal-clock mode (bit 10 = 0) the counter then drops by one on every clock.
- R3: In internal-clock mode, the mode field in bits 9..7 selects the external start edge: 001 rising, 010 falling, 011 both, and 000 none. A selected edge on `ext_in` loads the counter on the third clock edge after the input changes. An edge that is not selected has no effect.
- R4: The control word reads back bit 6 as 0 and bit 0 as 0, and returns the mode field exactly as it was written.
- R5: With bit 4 set (reload mode), a step from 0 loads the reload value, and counting continues.
- R6: With bit 4 clear (one-shot mode), a step from 0 leaves the counter at all ones and stops it.
- R7: In one-shot mode, `tmr_out` equals (counting XOR bit 5). It is high while counting when bit 5 is 0, and low while counting when bit 5 is 1.
- R8: In reload mode, `tmr_out` equals bit 5 right after a start and flips on every underflow.
- R9: Bit 2 is set by every underflow. Writing 0 to bit 2 clears it, and writing 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the bit set.
- R10: `irq` is high exactly when bit 3 (interrupt enable) and bit 2 are both 1.
- R11: In event-count mode (bit 10 = 1), a software start loads the counter. Each selected edge of `ext_in` (same codes as R3) then lowers it by one. With code 000, or with no edge, the counter holds.
- R12: With count enable at 0, starts and external events are ignored. Clearing count enable halts counting from the cycle after the write.
- R13: A start that arrives while the counter is running reloads it from the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address: 0 control, 1 reload, 2 counter |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| ext_in | input | 1 | Asynchronous external trigger / event input |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect on the edge that samples it, so the counter shows the reload value one clock after a start write. After that, the count falls by exactly one per edge. An `ext_in` change passes two synchroniser stages and an edge register, so it acts on the third edge after it. The bench checks both the edge just before and the edge that triggers. The bench drives and samples on the falling clock edge and counts the rising edges between a stimulus and its check, so each expected counter, flag and pin value comes from that exact edge count.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;

  localparam int B_START = 0;
  localparam int B_EN    = 1;
  localparam int B_FLAG  = 2;
  localparam int B_IEN   = 3;
  localparam int B_RLD   = 4;
  localparam int B_POL   = 5;
  localparam int B_MODE  = 7;
  localparam int B_EVT   = 10;

  typedef struct packed {
    logic       evt_mode;
    logic [2:0] mode;
    logic       pol;
    logic       rld;
    logic       ien;
    logic       flag;
    logic       en;
  } ctl_t;
endpackage

// File: rtl/rtmr_edge.sv
module rtmr_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= din;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

  always_comb begin
    case (sel)
      2'b01:   hit = rise;
      2'b10:   hit = fall;
      2'b11:   hit = rise | fall;
      default: hit = 1'b0;
    endcase
  end

  // One detection per edge: a rising edge is never seen on two cycles running.
  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/rtmr_core.sv
module rtmr_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         tick,
  input  logic         cnt_en,
  input  logic         rld,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         running,
  output logic         tog,
  output logic         uflow
);
  logic at_zero;

  assign at_zero = (cnt == '0);
  assign uflow   = running & cnt_en & tick & ~start & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      tog     <= 1'b0;
    end else if (start) begin
      cnt     <= reload;
      running <= 1'b1;
      tog     <= 1'b0;
    end else if (!cnt_en) begin
      running <= 1'b0;
    end else if (running && tick) begin
      if (at_zero) begin
        if (rld) begin
          cnt <= reload;
          tog <= ~tog;
        end else begin
          cnt     <= '1;
          running <= 1'b0;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assert_start_loads_R13: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && cnt == $past(reload)));
  assert_reload_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && rld) |=> (running && cnt == $past(reload)));
  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !rld) |=> (!running && cnt == '1));
  assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(cnt));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              ext_in,
  output logic              tmr_out,
  output logic              irq
);
  ctl_t         ctl;
  logic [W-1:0] reload_q;
  logic [W-1:0] cnt;
  logic         running, tog, uflow, ext_hit;
  logic         wr_ctl, wr_rld, sw_start, start, tick;
  logic [1:0]   edge_sel;

  assign wr_ctl   = bus_sel & bus_wr & (bus_addr == A_CTRL);
  assign wr_rld   = bus_sel & bus_wr & (bus_addr == A_RELOAD);
  assign sw_start = wr_ctl & bus_wdata[B_START] & bus_wdata[B_EN];
  assign edge_sel = ctl.mode[2] ? 2'b00 : ctl.mode[1:0];

  assign start = ctl.evt_mode ? sw_start : (sw_start | (ext_hit & ctl.en));
  assign tick  = ctl.evt_mode ? ext_hit : 1'b1;

  rtmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk (clk),
    .rst_n (rst_n),
    .din (ext_in),
    .sel (edge_sel),
    .hit (ext_hit)
  );

  rtmr_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tick    (tick),
    .cnt_en  (ctl.en),
    .rld     (ctl.rld),
    .reload  (reload_q),
    .cnt     (cnt),
    .running (running),
    .tog     (tog),
    .uflow   (uflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      reload_q <= '0;
    end else begin
      if (wr_rld) reload_q <= bus_wdata;
      if (wr_ctl) begin
        ctl.evt_mode <= bus_wdata[B_EVT];
        ctl.mode     <= bus_wdata[B_MODE+2:B_MODE];
        ctl.pol      <= bus_wdata[B_POL];
        ctl.rld      <= bus_wdata[B_RLD];
        ctl.ien      <= bus_wdata[B_IEN];
        ctl.en       <= bus_wdata[B_EN];
      end
      if (uflow) ctl.flag <= 1'b1;
      else if (wr_ctl && !bus_wdata[B_FLAG]) ctl.flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_EVT]             = ctl.evt_mode;
        bus_rdata[B_MODE+2:B_MODE]   = ctl.mode;
        bus_rdata[B_POL]             = ctl.pol;
        bus_rdata[B_RLD]             = ctl.rld;
        bus_rdata[B_IEN]             = ctl.ien;
        bus_rdata[B_FLAG]            = ctl.flag;
        bus_rdata[B_EN]              = ctl.en;
      end
      A_RELOAD: bus_rdata = reload_q;
      A_COUNT:  bus_rdata = cnt;
      default:  bus_rdata = '0;
    endcase
  end

  assign tmr_out = ctl.rld ? (tog ^ ctl.pol) : (running ^ ctl.pol);
  assign irq     = ctl.ien & ctl.flag;

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> (bus_addr != A_CTRL) || bus_rdata[B_FLAG]);
  assert_flag_w1_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && bus_wdata[B_FLAG] && ctl.flag) |=> ctl.flag);
  assert_toggle_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && ctl.rld && !(wr_ctl && (bus_wdata[B_POL] != ctl.pol || !bus_wdata[B_RLD])))
      |=> (tmr_out != $past(tmr_out)));
endmodule

// File: tb/test_reload_timer.sv
module test_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_in = 1'b0;
  logic        tmr_out;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  reload_timer i_reload_timer (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .ext_in (ext_in), .tmr_out (tmr_out), .irq (irq)
  );

  typedef struct packed {
    logic [15:0] rl;
    logic        rld;
    logic        pol;
    logic        ien;
    logic [7:0]  n;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'd5,  1'b0, 1'b0, 1'b0, 8'd3},
    '{16'd5,  1'b0, 1'b0, 1'b1, 8'd6},
    '{16'd5,  1'b0, 1'b1, 1'b0, 8'd5},
    '{16'd3,  1'b1, 1'b0, 1'b1, 8'd4},
    '{16'd3,  1'b1, 1'b1, 1'b0, 8'd9},
    '{16'd0,  1'b1, 1'b0, 1'b1, 8'd3},
    '{16'd0,  1'b0, 1'b0, 1'b0, 8'd1},
    '{16'd10, 1'b1, 1'b0, 1'b1, 8'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse();
    ext_in = 1'b1; repeat (4) @(negedge clk);
    ext_in = 1'b0; repeat (4) @(negedge clk);
  endtask

  // R3: external start in internal-clock mode, one-shot, reload 20
  task automatic ext_case(input logic [2:0] mode, input logic rising, input logic fires);
    logic [15:0] d;
    do_reset();
    ext_in = ~rising;
    repeat (4) @(negedge clk);
    wr(2'd1, 16'd20);
    wr(2'd0, 16'h0002 | (16'(mode) << 7));
    ext_in = rising;
    repeat (2) @(negedge clk);
    rd(2'd2, d); chk("R3 before third edge", d, 0);
    @(negedge clk);
    rd(2'd2, d); chk("R3 on third edge", d, fires ? 20 : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    do_reset();

    // R1 reset state
    rd(2'd0, d); chk("R1 control", d, 0);
    rd(2'd1, d); chk("R1 reload", d, 0);
    rd(2'd2, d); chk("R1 counter", d, 0);
    chk("R1 tmr_out", tmr_out, 0);
    chk("R1 irq", irq, 0);

    // table walk: R2 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      int cyc, k;
      logic [15:0] e_cnt;
      logic e_flag, e_out;
      vec_t v;
      v = VECS[i];
      cyc = int'(v.rl) + 1;
      if (int'(v.n) < cyc) begin
        e_cnt = v.rl - 16'(v.n); e_flag = 1'b0;
        e_out = v.rld ? v.pol : ~v.pol;
      end else begin
        e_flag = 1'b1;
        if (v.rld) begin
          k = int'(v.n) / cyc;
          e_cnt = v.rl - 16'(int'(v.n) % cyc);
          e_out = v.pol ^ k[0];
        end else begin
          e_cnt = 16'hFFFF; e_out = v.pol;
        end
      end
      wr(2'd1, v.rl);
      wr(2'd0, 16'h0003 | (16'(v.ien) << 3) | (16'(v.rld) << 4) | (16'(v.pol) << 5));
      repeat (int'(v.n)) @(negedge clk);
      rd(2'd2, d); chk(v.rld ? "R2/R5 counter" : "R2/R6 counter", d, e_cnt);
      rd(2'd0, d); chk("R9 flag", d[2], e_flag);
      chk(v.rld ? "R8 tmr_out" : "R7 tmr_out", tmr_out, e_out);
      chk("R10 irq", irq, v.ien & e_flag);
    end

    // R4 readback and R12 disabled start
    do_reset();
    wr(2'd1, 16'd7);
    wr(2'd0, 16'h01C1);
    rd(2'd0, d); chk("R4 control readback", d, 16'h0180);
    wr(2'd0, 16'h0380);
    rd(2'd0, d); chk("R4 mode top bit", d, 16'h0380);
    wr(2'd0, 16'h0001);
    repeat (3) @(negedge clk);
    rd(2'd2, d); chk("R12 start ignored", d, 0);
    wr(2'd0, 16'h0080);
    pulse();
    rd(2'd2, d); chk("R12 edge ignored", d, 0);

    // R12 halt
    wr(2'd0, 16'h0003);
    repeat (2) @(negedge clk);
    rd(2'd2, d); chk("R2 running", d, 5);
    wr(2'd0, 16'h0000);
    rd(2'd2, d); chk("R12 last step", d, 4);
    repeat (3) @(negedge clk);
    rd(2'd2, d); chk("R12 halted", d, 4);

    // R13 restart
    wr(2'd1, 16'd50);
    wr(2'd0, 16'h0003);
    repeat (10) @(negedge clk);
    rd(2'd2, d); chk("R13 before restart", d, 40);
    wr(2'd0, 16'h0003);
    rd(2'd2, d); chk("R13 restart", d, 50);

    // R9 / R10 flag handling
    do_reset();
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0003);
    @(negedge clk);
    rd(2'd0, d); chk("R9 set by underflow", d[2], 1);
    chk("R10 irq disabled", irq, 0);
    wr(2'd0, 16'h000E);
    rd(2'd0, d); chk("R9 write one keeps", d[2], 1);
    chk("R10 irq enabled", irq, 1);
    wr(2'd0, 16'h000A);
    rd(2'd0, d); chk("R9 write zero clears", d[2], 0);
    chk("R10 irq dropped", irq, 0);
    wr(2'd0, 16'h0013);
    wr(2'd0, 16'h0012);
    rd(2'd0, d); chk("R9 set wins", d[2], 1);

    // R3 edge selection
    ext_case(3'b001, 1'b1, 1'b1);
    ext_case(3'b001, 1'b0, 1'b0);
    ext_case(3'b010, 1'b0, 1'b1);
    ext_case(3'b010, 1'b1, 1'b0);
    ext_case(3'b011, 1'b1, 1'b1);
    ext_case(3'b011, 1'b0, 1'b1);
    ext_case(3'b000, 1'b1, 1'b0);

    // R11 event-count mode
    do_reset();
    repeat (4) @(negedge clk);
    wr(2'd1, 16'd9);
    wr(2'd0, 16'h0483);
    repeat (5) @(negedge clk);
    rd(2'd2, d); chk("R11 hold without events", d, 9);
    pulse(); pulse();
    rd(2'd2, d); chk("R11 rising edges", d, 7);
    wr(2'd0, 16'h0582);
    pulse();
    rd(2'd2, d); chk("R11 both edges", d, 5);
    wr(2'd0, 16'h0402);
    pulse();
    rd(2'd2, d); chk("R11 no event code", d, 5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule